// File: doc/BRIEF.md
# Security-Filtered Timer Register Bank

This block is a small memory-mapped bank of up-counting timers. It sits behind a simple register bus and decides, for every transfer, whether the transfer may reach the register it addresses. Each transfer carries a non-secure flag. A secure transfer may reach any register. A non-secure transfer may reach a timer's registers only when that timer's bit in a permission register is set. The permission register itself answers only secure transfers.

The bank holds three counters: two general-purpose timers and one debug timer. The permission register also carries bits for two watchdog slots. These bits are stored and read back but have no function here. Each counter has a match value, a control word with a run bit and a restart-on-match bit, a write-only clear register and a read-only count. While it runs, a counter raises a one-cycle interrupt pulse when its count reaches the match value. A refused transfer reads as zero, its write is dropped, and it raises a one-cycle error pulse. Secure software sets the permission bits once, and non-secure software then drives the timers it has been given.

Top module: `sectmr_bank`

## Requirements
- R1: After reset the permission register holds 0x01 (only the debug timer open to non-secure transfers), every timer is stopped with match 0 and count 0, and all interrupt and error outputs are low.
- R2: The permission register is at address 0x00. Its field positions are bit 4 watchdog 0, bit 3 watchdog 1, bit 2 general timer A, bit 1 general timer B and bit 0 debug timer. A secure write stores bits 4:0, and a read returns them with all upper bits zero.
- R3: A non-secure access to address 0x00 is refused: the write is dropped, the read returns 0 and the error output pulses.
- R4: The three timer windows start at 0x00 (general timer A, permission bit 2), 0x20 (debug timer, bit 0) and 0x40 (general timer B, bit 1). A non-secure access to a window succeeds exactly when that window's bit is 1. Secure accesses always succeed.
- R5: A refused timer access returns read data 0, changes no timer register and drives the error output high for exactly the cycle after that access only.
- R6: Within a window, +0x04 is the match register, +0x08 the clear register (reads 0), +0x0C the control register (bit 0 run, bit 1 restart-on-match, reads back bits 1:0) and +0x10 the read-only count. Read data appears on the cycle after the read strobe and is 0 when no read was made.
- R7: A running counter increments by one per clock. A stopped counter holds its count.
- R8: Interrupt bit 0 belongs to timer A, bit 1 to the debug timer and bit 2 to timer B. It is high for one cycle, in the cycle after a running counter's count equals its match value. A counter that has just been started from count 0 with match M therefore pulses M+1 cycles after the starting write.
- R9: With restart-on-match set, the count is 0 in the cycle after it equals the match value, so interrupts repeat every M+1 cycles.
- R10: Any permitted write to a clear register sets that timer's count to 0, whatever the data, and it takes precedence over counting.
- R11: An address outside the registers listed above reads 0, ignores writes and never raises the error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 8 | Byte address of the transfer |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe, one transfer per cycle |
| bus_rd_i | input | 1 | Read strobe |
| bus_ns_i | input | 1 | 1 marks the transfer as non-secure |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| access_err_o | output | 1 | One-cycle pulse after a refused transfer |
| match_irq_o | output | 3 | Per-timer match interrupt pulses |

## Verification
The hardest case to reach from the ports is a mix of permission states and transfer origins that leaves the register file in a state no single directed test predicts. For example, a non-secure write that is dropped because secure software closed a window a few transfers earlier. Random stimulus from a fixed seed reprograms the permission register, flips the non-secure flag and spreads accesses across every window, the permission register and unmapped addresses. A bench model tracks which writes should have landed. Directed sequences then pin the counting, interrupt spacing and restart timing to exact cycles.

// File: rtl/sectmr_pkg.sv
// Shared constants, types and helpers for the security-filtered timer bank.
// Assumes three counters whose windows sit at 32-byte strides from address 0.
package sectmr_pkg;

    localparam int NUM_TMR   = 3;
    localparam int TMR_IDX_W = $clog2(NUM_TMR);
    localparam int SEC_W     = 5;
    localparam int WIN_SHIFT = 5;
    localparam int CTL_W     = 2;

    localparam logic [SEC_W-1:0] SEC_RST = 5'b00001;

    localparam logic [WIN_SHIFT-1:0] OFF_MATCH = 5'h04;
    localparam logic [WIN_SHIFT-1:0] OFF_CLEAR = 5'h08;
    localparam logic [WIN_SHIFT-1:0] OFF_CTL   = 5'h0C;
    localparam logic [WIN_SHIFT-1:0] OFF_COUNT = 5'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_CLEAR,
        SEL_CTL,
        SEL_COUNT
    } reg_sel_e;

    typedef struct packed {
        logic                 hit_sec;
        logic                 hit_tmr;
        logic [TMR_IDX_W-1:0] tmr;
        reg_sel_e             sel;
    } dec_t;

    // Permission-bit position for each timer window (A -> 2, debug -> 0, B -> 1)
    function automatic logic [2:0] perm_bit_of(input logic [TMR_IDX_W-1:0] t);
        case (t)
            2'd0:    perm_bit_of = 3'd2;
            2'd1:    perm_bit_of = 3'd0;
            2'd2:    perm_bit_of = 3'd1;
            default: perm_bit_of = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/sectmr_addr_dec.sv
// Address decoder: splits a byte address into the permission register, a
// timer window with a register select, or nothing. Purely combinational.
// Assumes ADDR_W leaves room for at least NUM_TMR windows of 2**WIN_SHIFT bytes.
module sectmr_addr_dec
    import sectmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    localparam int WIN_W = ADDR_W - WIN_SHIFT;

    logic [WIN_W-1:0]     win;
    logic [WIN_SHIFT-1:0] off;
    reg_sel_e             sel;

    assign win = addr_i[ADDR_W-1:WIN_SHIFT];
    assign off = addr_i[WIN_SHIFT-1:0];

    // Map the in-window offset to a register select
    always_comb begin
        case (off)
            OFF_MATCH: sel = SEL_MATCH;
            OFF_CLEAR: sel = SEL_CLEAR;
            OFF_CTL:   sel = SEL_CTL;
            OFF_COUNT: sel = SEL_COUNT;
            default:   sel = SEL_NONE;
        endcase
    end

    // Build the decode result; address zero is the permission register
    always_comb begin
        dec_o         = '0;
        dec_o.sel     = SEL_NONE;
        dec_o.hit_sec = (addr_i == '0);
        if (!dec_o.hit_sec && (int'(win) < NUM_TMR) && (sel != SEL_NONE)) begin
            dec_o.hit_tmr = 1'b1;
            dec_o.tmr     = win[TMR_IDX_W-1:0];
            dec_o.sel     = sel;
        end
    end

endmodule

// File: rtl/sectmr_gate.sv
// Security gate: holds the permission register and judges each transfer.
// A transfer is refused when it is non-secure and targets either the
// permission register or a timer whose permission bit is clear.
// Assumes at most one transfer (read and/or write) per cycle.
module sectmr_gate
    import sectmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic             ns_i,
    input  dec_t             dec_i,
    input  logic [SEC_W-1:0] wdata_i,
    output logic [SEC_W-1:0] perm_o,
    output logic             allow_o,
    output logic             err_o
);
    logic [SEC_W-1:0] perm_q;
    logic             err_q;
    logic             refused;
    logic             win_open;

    // Look up the addressed timer's permission bit
    always_comb begin
        win_open = perm_q[perm_bit_of(dec_i.tmr)];
    end

    // Decide whether the current transfer is refused
    always_comb begin
        refused = (wr_i || rd_i) && ns_i &&
                  (dec_i.hit_sec || (dec_i.hit_tmr && !win_open));
    end

    // Permission register: secure writes only
    always_ff @(posedge clk) begin
        if (!rst_n)                             perm_q <= SEC_RST;
        else if (wr_i && !ns_i && dec_i.hit_sec) perm_q <= wdata_i;
    end

    // One-cycle error pulse after a refused transfer
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= refused;
    end

    assign perm_o  = perm_q;
    assign allow_o = !refused;
    assign err_o   = err_q;

    // R3
    perm_ns_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ns_i && dec_i.hit_sec) |=> $stable(perm_q));

    // R11
    unmapped_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_i.hit_sec && !dec_i.hit_tmr) |=> !err_q);

endmodule

// File: rtl/sectmr_counter.sv
// One up-counter with match register, control word and clear strobe.
// Control bit 0 runs the counter, bit 1 restarts it at the match value.
// The interrupt is registered: it pulses the cycle after count == match.
// Assumes write strobes arrive already filtered by the security gate.
module sectmr_counter
    import sectmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_match_i,
    input  logic             wr_clear_i,
    input  logic             wr_ctl_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] match_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] match_q;
    logic [CTL_W-1:0] ctl_q;
    logic             irq_q;
    logic             at_match;
    logic             running;
    logic             restart;

    assign at_match = (cnt_q == match_q);
    assign running  = ctl_q[0];
    assign restart  = ctl_q[1];

    // Match register
    always_ff @(posedge clk) begin
        if (!rst_n)          match_q <= '0;
        else if (wr_match_i) match_q <= wdata_i;
    end

    // Control register: run and restart-on-match bits
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_q <= '0;
        else if (wr_ctl_i) ctl_q <= wdata_i[CTL_W-1:0];
    end

    // Count: clear write first, then restart or increment while running
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (wr_clear_i)          cnt_q <= '0;
        else if (running && restart && at_match) cnt_q <= '0;
        else if (running)             cnt_q <= cnt_q + 1'b1;
    end

    // Match interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= running && at_match;
    end

    assign match_o = match_q;
    assign ctl_o   = ctl_q;
    assign count_o = cnt_q;
    assign irq_o   = irq_q;

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wr_clear_i && !(restart && at_match)) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_clear_i) |=> $stable(cnt_q));

    // R9
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && restart && at_match) |=> (cnt_q == '0));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/sectmr_bank.sv
// Top of the security-filtered timer bank. Decodes each bus transfer,
// passes it through the security gate, fans permitted writes out to the
// counters and returns registered read data one cycle after the read strobe.
// Assumes CNT_W <= DATA_W.
module sectmr_bank
    import sectmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic               bus_ns_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               access_err_o,
    output logic [NUM_TMR-1:0] match_irq_o
);
    dec_t              dec;
    logic [SEC_W-1:0]  perm;
    logic              allow;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;

    logic [CNT_W-1:0]  match_a [NUM_TMR];
    logic [CTL_W-1:0]  ctl_a   [NUM_TMR];
    logic [CNT_W-1:0]  count_a [NUM_TMR];

    sectmr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr_i),
        .dec_o  (dec)
    );

    sectmr_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .rd_i    (bus_rd_i),
        .ns_i    (bus_ns_i),
        .dec_i   (dec),
        .wdata_i (bus_wdata_i[SEC_W-1:0]),
        .perm_o  (perm),
        .allow_o (allow),
        .err_o   (access_err_o)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        logic hit;
        assign hit = bus_wr_i && allow && dec.hit_tmr && (dec.tmr == TMR_IDX_W'(g));

        sectmr_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_match_i (hit && (dec.sel == SEL_MATCH)),
            .wr_clear_i (hit && (dec.sel == SEL_CLEAR)),
            .wr_ctl_i   (hit && (dec.sel == SEL_CTL)),
            .wdata_i    (bus_wdata_i[CNT_W-1:0]),
            .match_o    (match_a[g]),
            .ctl_o      (ctl_a[g]),
            .count_o    (count_a[g]),
            .irq_o      (match_irq_o[g])
        );

        // R5
        refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && bus_ns_i && !perm[perm_bit_of(TMR_IDX_W'(g))] &&
             dec.hit_tmr && (dec.tmr == TMR_IDX_W'(g))) |=> $stable(match_a[g]));
    end

    // Select the read value for a permitted transfer
    always_comb begin
        rd_val = '0;
        if (allow && dec.hit_sec) begin
            rd_val = DATA_W'(perm);
        end else if (allow && dec.hit_tmr) begin
            for (int i = 0; i < NUM_TMR; i++) begin
                if (dec.tmr == TMR_IDX_W'(i)) begin
                    case (dec.sel)
                        SEL_MATCH: rd_val = DATA_W'(match_a[i]);
                        SEL_CTL:   rd_val = DATA_W'(ctl_a[i]);
                        SEL_COUNT: rd_val = DATA_W'(count_a[i]);
                        default:   rd_val = '0;
                    endcase
                end
            end
        end
    end

    // Registered read data, zero when no read was made
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= rd_val;
        else               rdata_q <= '0;
    end

    assign bus_rdata_o = rdata_q;

    // R5
    err_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_err_o |-> $past(bus_ns_i && (bus_wr_i || bus_rd_i)));

    // R5
    refused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_err_o |-> (bus_rdata_o == '0));

endmodule

// File: tb/sim_sectmr_bank.sv
module sim_sectmr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic        ns = 1'b0;
    logic [31:0] rdata;
    logic        err;
    logic [2:0]  irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [4:0]  perm_m;
    logic [31:0] match_m [3];
    logic [1:0]  ctl_m [3];

    always #5 clk = ~clk;

    sectmr_bank u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_wr_i     (wr),
        .bus_rd_i     (rd),
        .bus_ns_i     (ns),
        .bus_rdata_o  (rdata),
        .access_err_o (err),
        .match_irq_o  (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One bus transfer; returns the read data and error flag seen after the edge
    task automatic xfer(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d,
                        input bit n, output logic [31:0] rd_o, output logic err_o);
        @(negedge clk);
        wr = w; rd = r; addr = a; wdata = d; ns = n;
        @(posedge clk);
        #1;
        rd_o = rdata; err_o = err;
        wr = 1'b0; rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        perm_m = 5'b00001;
        for (int i = 0; i < 3; i++) begin
            match_m[i] = '0;
            ctl_m[i] = '0;
        end
    endtask

    // Permission bit of each window: 0x00 -> 2, 0x20 -> 0, 0x40 -> 1
    function automatic int perm_bit(input int win);
        case (win)
            0:       perm_bit = 2;
            1:       perm_bit = 0;
            default: perm_bit = 1;
        endcase
    endfunction

    function automatic bit is_mapped_tmr(input logic [7:0] a);
        logic [4:0] off;
        off = a[4:0];
        return (a != 8'h00) && (int'(a[7:5]) < 3) &&
               (off == 5'h04 || off == 5'h08 || off == 5'h0C || off == 5'h10);
    endfunction

    function automatic bit permitted(input logic [7:0] a, input bit n);
        if (a == 8'h00) return !n;
        if (!is_mapped_tmr(a)) return 1'b1;
        return !n || perm_m[perm_bit(int'(a[7:5]))];
    endfunction

    function automatic bit refused(input logic [7:0] a, input bit n);
        return !permitted(a, n);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a, input bit n);
        int w;
        if (!permitted(a, n)) return '0;
        if (a == 8'h00) return {27'd0, perm_m};
        if (!is_mapped_tmr(a)) return '0;
        w = int'(a[7:5]);
        case (a[4:0])
            5'h04:   return match_m[w];
            5'h0C:   return {30'd0, ctl_m[w]};
            default: return '0;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d, input bit n);
        int w;
        if (!permitted(a, n)) return;
        if (a == 8'h00) begin
            perm_m = d[4:0];
            return;
        end
        if (!is_mapped_tmr(a)) return;
        w = int'(a[7:5]);
        case (a[4:0])
            5'h04:   match_m[w] = d;
            5'h0C:   ctl_m[w] = d[1:0];
            default: ;
        endcase
    endtask

    initial begin
        logic [31:0] r;
        logic        e;
        void'($urandom(32'h5EC7));
        do_reset();
        #1;

        // R1 reset state
        chk("R1 irq", {29'd0, irq}, 32'd0);
        chk("R1 err", {31'd0, err}, 32'd0);
        xfer(0, 1, 8'h00, 0, 0, r, e);
        chk("R1 perm reset", r, 32'h1);
        xfer(0, 1, 8'h44, 0, 0, r, e);
        chk("R1 match reset", r, 32'h0);
        xfer(0, 1, 8'h50, 0, 0, r, e);
        chk("R1 count reset", r, 32'h0);
        xfer(0, 1, 8'h2C, 0, 1, r, e);
        chk("R1 debug open ns err", {31'd0, e}, 32'd0);
        xfer(0, 1, 8'h0C, 0, 1, r, e);
        chk("R1 timer A locked err", {31'd0, e}, 32'd1);

        // Random phase: R2 R3 R4 R5 R6 R11 against the bench model
        for (int k = 0; k < 400; k++) begin
            logic [7:0]  a;
            logic [31:0] d;
            bit          n;
            bit          w;
            int          kind;
            kind = int'($urandom % 6);
            if (kind == 0) a = 8'h00;
            else if (kind == 1) a = ($urandom % 2) ? 8'(8'h60 + ($urandom % 32) * 4) : 8'h14;
            else a = 8'((($urandom % 3) * 32) + 4 * (1 + ($urandom % 4)));
            n = 1'($urandom % 2);
            w = 1'($urandom % 2);
            d = $urandom;
            if (a[4:0] == 5'h0C) d = d & 32'h2;
            xfer(w, !w, a, d, n, r, e);
            chk($sformatf("R5 err a=%0h ns=%0d", a, n), {31'd0, e}, {31'd0, refused(a, n)});
            if (!w) chk($sformatf("R6 read a=%0h ns=%0d", a, n), r, exp_read(a, n));
            else model_write(a, d, n);
        end
        chk("R7 no irq while stopped", {29'd0, irq}, 32'd0);

        // Directed corners
        do_reset();
        xfer(1, 0, 8'h00, 32'hFFFF_FFE5, 0, r, e);
        xfer(0, 1, 8'h00, 0, 0, r, e);
        chk("R2 perm upper bits zero", r, 32'h05);
        xfer(1, 0, 8'h00, 32'h1F, 1, r, e);
        chk("R3 ns perm write err", {31'd0, e}, 32'd1);
        idle(1);
        chk("R5 err one cycle", {31'd0, err}, 32'd0);
        xfer(0, 1, 8'h00, 0, 1, r, e);
        chk("R3 ns perm read zero", r, 32'h0);
        xfer(0, 1, 8'h00, 0, 0, r, e);
        chk("R3 perm unchanged", r, 32'h05);
        xfer(1, 0, 8'h04, 32'h55, 1, r, e);
        chk("R4 open window no err", {31'd0, e}, 32'd0);
        xfer(0, 1, 8'h04, 0, 0, r, e);
        chk("R4 open window write landed", r, 32'h55);
        xfer(1, 0, 8'h44, 32'h77, 1, r, e);
        chk("R5 locked write err", {31'd0, e}, 32'd1);
        xfer(0, 1, 8'h44, 0, 0, r, e);
        chk("R5 locked write dropped", r, 32'h0);
        xfer(1, 0, 8'h60, 32'h1, 1, r, e);
        chk("R11 unmapped write no err", {31'd0, e}, 32'd0);
        xfer(0, 1, 8'h60, 0, 0, r, e);
        chk("R11 unmapped read zero", r, 32'h0);

        // R7 / R10 on timer B (secure)
        xfer(1, 0, 8'h44, 32'd1000, 0, r, e);
        xfer(1, 0, 8'h4C, 32'd1, 0, r, e);
        idle(9);
        xfer(1, 0, 8'h4C, 32'd0, 0, r, e);
        xfer(0, 1, 8'h50, 0, 0, r, e);
        chk("R7 count after 10 cycles", r, 32'd10);
        idle(5);
        xfer(0, 1, 8'h50, 0, 0, r, e);
        chk("R7 stopped count holds", r, 32'd10);
        xfer(1, 0, 8'h48, 32'hDEAD, 0, r, e);
        xfer(0, 1, 8'h50, 0, 0, r, e);
        chk("R10 clear zeroes count", r, 32'd0);

        // R8 on timer A: match 5, pulse 6 cycles after start, once only
        xfer(1, 0, 8'h04, 32'd5, 0, r, e);
        xfer(1, 0, 8'h0C, 32'd1, 0, r, e);
        for (int c = 1; c <= 12; c++) begin
            idle(1);
            chk($sformatf("R8 timer A irq cycle %0d", c), {29'd0, irq}, (c == 6) ? 32'd1 : 32'd0);
        end
        xfer(1, 0, 8'h0C, 32'd0, 0, r, e);

        // R9 on debug timer via non-secure: match 3, period 4
        xfer(1, 0, 8'h24, 32'd3, 1, r, e);
        xfer(1, 0, 8'h2C, 32'd3, 1, r, e);
        for (int c = 1; c <= 16; c++) begin
            idle(1);
            chk($sformatf("R9 debug irq cycle %0d", c), {29'd0, irq}, (c % 4 == 0) ? 32'd2 : 32'd0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule